// File: doc/BRIEF.md
# Overcurrent Fault Disable Timer

This block is the digital model of the self-protection loop that sits beside a pair of full-bridge power stages. Each bridge presents one overcurrent comparator bit. That bit already stands for the summed current of both high-side switches of the bridge, so the block never looks at the switches one by one. A shared thermal fault bit and one enable request per bridge complete the inputs. For every bridge the block drives an active-low fault flag, in the manner of an open-drain pin, and a gated enable for the bridge's gate logic.

A comparator level that persists is qualified by a glitch filter with separate assert and release lags. The qualified level pulls the fault flag low. After a programmable delay the gated enable is switched off. It then stays off for a programmable disable window and comes back by itself. If the overcurrent is still present when it comes back, the sequence starts again, so the loop behaves as an automatic-retry current limiter instead of a latched trip. A gang option makes an overcurrent on any bridge trip every bridge together. A thermal fault pulls all flags low and holds every enable off for as long as it lasts, with no timed retry. Analog thresholds and RC constants are modelled purely as cycle counts.

Top module: `ocp_fault_timer`

## Requirements
- R1: After reset, with no overcurrent and no thermal fault, every faultN bit is 1 and every gatedEn bit equals its enReq bit.
- R2: The ocTrip bit of a bridge pulls faultN for that bridge low at the ON_LAG-th clock edge of an unbroken high run. It releases faultN at the OFF_LAG-th edge of an unbroken low run. A high run shorter than ON_LAG edges leaves faultN and gatedEn unchanged.
- R3: If faultN of a bridge falls at edge E, that bridge's gatedEn falls at edge E+delayCycles+2. With delayCycles = 0 it falls at E+2.
- R4: Once gatedEn falls at edge X because of an overcurrent, it stays low for offCycles+1 cycles and rises again at edge X+offCycles+1, with enReq high and no thermal fault.
- R5: If faultN is still low when the off window ends, gatedEn is high for exactly delayCycles+2 cycles and then falls again for a new off window.
- R6: Once a trip sequence has started, clearing the overcurrent during the delay does not cancel it: the off window still follows at the time given by R3.
- R7: With gangEn = 0 an overcurrent affects only its own bridge's gatedEn. With gangEn = 1 an overcurrent on any bridge drops every gatedEn at the same edge.
- R8: While thermalFault is 1, every faultN bit is 0 and every gatedEn bit is 0 in the same cycle, for as long as the fault lasts. Both follow again in the same cycle after it is removed.
- R9: When the enReq bit of a bridge is 0, its gatedEn is 0 regardless of fault state, and faultN is unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enReq | input | NUM_BR | Enable request per bridge |
| ocTrip | input | NUM_BR | Overcurrent comparator per bridge (summed high-side current) |
| thermalFault | input | 1 | Die over-temperature indication |
| gangEn | input | 1 | 1 = an overcurrent on any bridge trips all bridges |
| delayCycles | input | TW | Cycles from fault qualification to switch-off (R3) |
| offCycles | input | TW | Length of the disable window minus one (R4) |
| faultN | output | NUM_BR | Active-low fault flag per bridge |
| gatedEn | output | NUM_BR | Enable delivered to each bridge |

## Verification
The hardest situation to reach is the retry case. It needs an overcurrent that is still qualified at the exact edge where the off window ends, so that the control returns to running for a single cycle and starts a new delay at once. The stimulus holds the comparator high through an entire first trip. It then walks a cycle-by-cycle vector table that predicts the short high window and the second off window, and it repeats the same pattern with zero delay and a one-cycle off window, where the states are packed as tightly as they can be.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DELAY = 2'd1,
    ST_OFF   = 2'd2
  } brState_t;

  // strobes from control to the per-bridge timer
  typedef struct packed {
    logic loadDelay;
    logic loadOff;
    logic countDown;
  } timerCmd_t;

endpackage

// File: rtl/ocp_datapath.sv
module ocp_datapath
  import ocp_pkg::*;
#(
  parameter int NUM_BR  = 2,
  parameter int TW      = 16,
  parameter int ON_LAG  = 10,
  parameter int OFF_LAG = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_BR-1:0] ocTrip,
  input  logic [TW-1:0]     delayCycles,
  input  logic [TW-1:0]     offCycles,
  input  timerCmd_t         cmd [NUM_BR],
  output logic [NUM_BR-1:0] ocFilt,
  output logic [NUM_BR-1:0] timerZero
);

  localparam int MAX_LAG = (ON_LAG > OFF_LAG) ? ON_LAG : OFF_LAG;
  localparam int LW      = $clog2(MAX_LAG + 1);
  localparam logic [LW-1:0] ON_LIM  = LW'(ON_LAG - 1);
  localparam logic [LW-1:0] OFF_LIM = LW'(OFF_LAG - 1);

  for (genvar b = 0; b < NUM_BR; b++) begin : g_br
    logic [LW-1:0] runCnt;
    logic          filtQ;
    logic [TW-1:0] timer;

    // glitch filter: the output follows the raw level only after an unbroken run
    always_ff @(posedge clk) begin
      if (!rstN) begin
        runCnt <= '0;
        filtQ  <= 1'b0;
      end else if (ocTrip[b] == filtQ) begin
        runCnt <= '0;
      end else if (runCnt == (filtQ ? OFF_LIM : ON_LIM)) begin
        runCnt <= '0;
        filtQ  <= ocTrip[b];
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        timer <= '0;
      end else if (cmd[b].loadDelay) begin
        timer <= delayCycles;
      end else if (cmd[b].loadOff) begin
        timer <= offCycles;
      end else if (cmd[b].countDown && timer != '0) begin
        timer <= timer - 1'b1;
      end
    end

    assign ocFilt[b]    = filtQ;
    assign timerZero[b] = (timer == '0);
  end

endmodule

// File: rtl/ocp_control.sv
module ocp_control
  import ocp_pkg::*;
#(
  parameter int NUM_BR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_BR-1:0] ocFilt,
  input  logic              gangEn,
  input  logic [NUM_BR-1:0] timerZero,
  output timerCmd_t         cmd [NUM_BR],
  output logic [NUM_BR-1:0] offWin
);

  logic anyFault;
  assign anyFault = |ocFilt;

  for (genvar b = 0; b < NUM_BR; b++) begin : g_fsm
    brState_t st, stNext;
    logic     trig;

    assign trig = gangEn ? anyFault : ocFilt[b];

    always_comb begin
      stNext = st;
      cmd[b] = '0;
      unique case (st)
        ST_RUN: begin
          if (trig) begin
            stNext           = ST_DELAY;
            cmd[b].loadDelay = 1'b1;
          end
        end
        ST_DELAY: begin
          if (timerZero[b]) begin
            stNext         = ST_OFF;
            cmd[b].loadOff = 1'b1;
          end else begin
            cmd[b].countDown = 1'b1;
          end
        end
        ST_OFF: begin
          if (timerZero[b]) stNext = ST_RUN;
          else              cmd[b].countDown = 1'b1;
        end
        default: stNext = ST_RUN;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) st <= ST_RUN;
      else       st <= stNext;
    end

    assign offWin[b] = (st == ST_OFF);
  end

endmodule

// File: rtl/ocp_fault_timer.sv
module ocp_fault_timer
  import ocp_pkg::*;
#(
  parameter int NUM_BR  = 2,
  parameter int TW      = 16,
  parameter int ON_LAG  = 10,
  parameter int OFF_LAG = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_BR-1:0] enReq,
  input  logic [NUM_BR-1:0] ocTrip,
  input  logic              thermalFault,
  input  logic              gangEn,
  input  logic [TW-1:0]     delayCycles,
  input  logic [TW-1:0]     offCycles,
  output logic [NUM_BR-1:0] faultN,
  output logic [NUM_BR-1:0] gatedEn
);

  timerCmd_t         cmd [NUM_BR];
  logic [NUM_BR-1:0] ocFilt;
  logic [NUM_BR-1:0] timerZero;
  logic [NUM_BR-1:0] offWin;

  ocp_datapath #(
    .NUM_BR(NUM_BR), .TW(TW), .ON_LAG(ON_LAG), .OFF_LAG(OFF_LAG)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ocTrip(ocTrip),
    .delayCycles(delayCycles), .offCycles(offCycles),
    .cmd(cmd), .ocFilt(ocFilt), .timerZero(timerZero)
  );

  ocp_control #(.NUM_BR(NUM_BR)) u_ctl (
    .clk(clk), .rstN(rstN), .ocFilt(ocFilt), .gangEn(gangEn),
    .timerZero(timerZero), .cmd(cmd), .offWin(offWin)
  );

  assign faultN  = ~(ocFilt | {NUM_BR{thermalFault}});
  assign gatedEn = enReq & ~offWin & {NUM_BR{~thermalFault}};

endmodule

// File: rtl/ocp_fault_timer_chk.sv
module ocp_fault_timer_chk #(
  parameter int NUM_BR = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_BR-1:0] enReq,
  input logic [NUM_BR-1:0] ocTrip,
  input logic              thermalFault,
  input logic [NUM_BR-1:0] faultN,
  input logic [NUM_BR-1:0] gatedEn
);

  assert_req_gates_R9: assert property (@(posedge clk) disable iff (!rstN)
    (gatedEn & ~enReq) == '0);

  assert_thermal_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    thermalFault |-> gatedEn == '0);

  assert_thermal_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    thermalFault |-> faultN == '0);

  for (genvar b = 0; b < NUM_BR; b++) begin : g_chk
    // R2: a flag that falls without thermal cause needs the comparator high before
    assert_flag_needs_trip_R2: assert property (@(posedge clk) disable iff (!rstN)
      ($fell(faultN[b]) && !thermalFault && !$past(thermalFault)) |-> $past(ocTrip[b]));

    // R2: a flag released without thermal cause needs the comparator low before
    assert_flag_release_R2: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(faultN[b]) && !thermalFault && !$past(thermalFault)) |-> !$past(ocTrip[b]));
  end

endmodule

bind ocp_fault_timer ocp_fault_timer_chk #(.NUM_BR(NUM_BR)) u_chk (
  .clk(clk), .rstN(rstN), .enReq(enReq), .ocTrip(ocTrip),
  .thermalFault(thermalFault), .faultN(faultN), .gatedEn(gatedEn)
);

// File: tb/tb_ocp_fault_timer.sv
module tb_ocp_fault_timer;

  localparam int NB = 2;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NB-1:0] enReq = '0;
  logic [NB-1:0] ocTrip = '0;
  logic          thermalFault = 1'b0;
  logic          gangEn = 1'b0;
  logic [TW-1:0] delayCycles = 16'd4;
  logic [TW-1:0] offCycles = 16'd6;
  logic [NB-1:0] faultN;
  logic [NB-1:0] gatedEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ocp_fault_timer #(.NUM_BR(NB), .TW(TW), .ON_LAG(3), .OFF_LAG(2)) dut (
    .clk(clk), .rstN(rstN), .enReq(enReq), .ocTrip(ocTrip),
    .thermalFault(thermalFault), .gangEn(gangEn),
    .delayCycles(delayCycles), .offCycles(offCycles),
    .faultN(faultN), .gatedEn(gatedEn)
  );

  // {enReq, ocTrip, expected faultN, expected gatedEn}; delay 4, off 6, lags 3/2
  localparam int NV = 30;
  localparam logic [7:0] VEC [NV] = '{
    8'b11_01_11_11, 8'b11_01_11_11, 8'b11_01_10_11, 8'b11_01_10_11,
    8'b11_01_10_11, 8'b11_01_10_11, 8'b11_01_10_11, 8'b11_01_10_11,
    8'b11_01_10_10, 8'b11_01_10_10, 8'b11_01_10_10, 8'b11_01_10_10,
    8'b11_01_10_10, 8'b11_01_10_10, 8'b11_01_10_10, 8'b11_01_10_11,
    8'b11_01_10_11, 8'b11_01_10_11, 8'b11_01_10_11, 8'b11_01_10_11,
    8'b11_01_10_11, 8'b11_01_10_10, 8'b11_00_10_10, 8'b11_00_11_10,
    8'b11_00_11_10, 8'b11_00_11_10, 8'b11_00_11_10, 8'b11_00_11_10,
    8'b11_00_11_11, 8'b11_00_11_11
  };

  task automatic check(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    enReq = 2'b11;
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    check("R1 faultN after reset", faultN, 2'b11);
    check("R1 gatedEn after reset", gatedEn, 2'b11);

    // R2/R3/R4/R5 table, bridge 1 untouched also covers R7 ungated
    for (int v = 0; v < NV; v++) begin
      enReq  = VEC[v][7:6];
      ocTrip = VEC[v][5:4];
      step(1);
      check($sformatf("R2/R3/R4/R5 row %0d faultN", v), faultN, VEC[v][3:2]);
      check($sformatf("R3/R4/R5/R7 row %0d gatedEn", v), gatedEn, VEC[v][1:0]);
    end

    // R2 short pulse ignored
    ocTrip = 2'b01;
    step(2);
    ocTrip = 2'b00;
    for (int i = 0; i < 6; i++) begin
      check("R2 glitch faultN", faultN, 2'b11);
      check("R2 glitch gatedEn", gatedEn, 2'b11);
      step(1);
    end

    // R6 trip committed even if fault clears during delay
    ocTrip = 2'b01;
    step(3);
    check("R6 flag low", faultN, 2'b10);
    ocTrip = 2'b00;
    step(5);
    check("R6 still on before switch-off", gatedEn, 2'b11);
    step(1);
    check("R6 off after delay", gatedEn, 2'b10);
    step(6);
    check("R6 R4 off window end", gatedEn, 2'b10);
    step(1);
    check("R4 recovered", gatedEn, 2'b11);
    check("R2 released", faultN, 2'b11);
    step(5);

    // R7 ganged trip
    gangEn = 1'b1;
    ocTrip = 2'b10;
    step(3);
    check("R7 gang flag", faultN, 2'b01);
    step(5);
    check("R7 gang before off", gatedEn, 2'b11);
    step(1);
    check("R7 gang both off", gatedEn, 2'b00);
    ocTrip = 2'b00;
    step(20);
    check("R7 gang recovered", gatedEn, 2'b11);
    gangEn = 1'b0;

    // R3 R5 zero delay and one-cycle off window
    delayCycles = '0;
    offCycles = '0;
    ocTrip = 2'b01;
    step(3);
    check("R3 zero delay flag", faultN, 2'b10);
    step(1);
    check("R3 zero delay E+1", gatedEn, 2'b11);
    step(1);
    check("R3 zero delay E+2", gatedEn, 2'b10);
    step(1);
    check("R4 one-cycle window", gatedEn, 2'b11);
    step(1);
    check("R5 retry high", gatedEn, 2'b11);
    step(1);
    check("R5 retry off again", gatedEn, 2'b10);
    ocTrip = 2'b00;
    step(10);
    check("R5 settled", gatedEn, 2'b11);
    delayCycles = 16'd4;
    offCycles = 16'd6;

    // R8 thermal
    thermalFault = 1'b1;
    #1;
    check("R8 thermal flags", faultN, 2'b00);
    check("R8 thermal enables", gatedEn, 2'b00);
    step(25);
    check("R8 no timed retry", gatedEn, 2'b00);
    thermalFault = 1'b0;
    #1;
    check("R8 release enables", gatedEn, 2'b11);
    check("R8 release flags", faultN, 2'b11);
    step(1);

    // R9 request gating
    enReq = 2'b01;
    step(1);
    check("R9 one request", gatedEn, 2'b01);
    enReq = 2'b00;
    step(1);
    check("R9 no request", gatedEn, 2'b00);
    check("R9 flags untouched", faultN, 2'b11);
    enReq = 2'b11;
    step(1);
    check("R9 restored", gatedEn, 2'b11);

    finishRun();
  end

endmodule